// File: doc/BRIEF.md
# USB device state tracker

This block follows the enumeration progress of a USB function controller. It takes snapshots of a seven-flag status word, compares each new snapshot with the previous accepted one, and keeps the device in one of five ordered states: attached, powered, default, addressed and configured. A status change never makes the state jump. The block moves the state one level at a time toward the level that the changed flag calls for, and it emits a separate event code for each level it passes. A change in the suspend flag produces its own bus-idle or bus-active event and does not touch the state.

The surrounding logic presents a status sample with `stat_valid` while `stat_ready` is high. It then receives a sequence of `evt_valid`/`evt_code` pulses, at most one per cycle, and `dev_state` tracks each step. `stat_ready` goes high again after the last step. What to do with each event is left to the consumer.

Top module: `usbst_tracker`

## Requirements
- R1: After reset `dev_state` is attached (0), `evt_valid` is low, `stat_ready` is high and the remembered status word is all zeros.
- R2: State encoding on `dev_state`: attached 0, powered 1, default 2, addressed 3, configured 4. No other value ever appears.
- R3: Status bit positions: [0] attach, [1] bus reset, [2] default, [3] suspend, [4] remote wakeup, [5] addressed, [6] configured. An accepted sample is compared bit by bit with the previous accepted sample. A sample equal to the previous one causes no event.
- R4: An upward step emits the code of the level it leaves: attached→powered 1, powered→default 2, default→addressed 3, addressed→configured 4.
- R5: A downward step emits: configured→addressed 5, addressed→default 2, default→powered 6, powered→attached 7.
- R6: Target level for each flag change. Attach: set→powered, cleared→attached. Bus reset: set→powered going down; cleared→nothing. Default: set→default, cleared→powered. Addressed: set→addressed, cleared→default. Configured: set→configured, cleared→addressed.
- R7: A change whose target lies in the opposite direction from the one it asks for, or equals the current level, produces no event and no state change.
- R8: Suspend set emits code 8 and suspend cleared emits code 9. Neither changes `dev_state`.
- R9: A change of the remote-wakeup bit alone produces no event and no state change.
- R10: When several flags change in one sample, they are handled in the order attach, bus reset, default, suspend, addressed, configured. Each flag's walk completes before the next flag starts.
- R11: At most one event is emitted per cycle. `dev_state` changes only in a cycle that carries an event, and only by one level.
- R12: `stat_ready` is low while events from the last sample are still pending. A sample offered then is ignored. One cycle after `stat_ready` is high, `evt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_valid | input | 1 | A status sample is offered |
| stat_word | input | 7 | Status flags, layout as in R3 |
| stat_ready | output | 1 | High when a new sample can be taken |
| dev_state | output | 3 | Current device state, encoding as in R2 |
| evt_valid | output | 1 | An event code is present this cycle |
| evt_code | output | 4 | Event code, values as in R4, R5, R8 |

## Verification
The assertions assume that reset is asserted from time zero and that `stat_word` carries known values whenever `stat_valid` is high. Under those assumptions the step properties hold for any sequence of samples. The stimulus waits for `stat_ready` before it offers a real sample, and it drives only defined words. Samples offered while busy are deliberately complemented words, so that a wrongly accepted one shows up in the event trace.

// File: rtl/usbst_pkg.sv
package usbst_pkg;

  localparam int FLAG_W    = 7;
  localparam int F_ATTACH  = 0;
  localparam int F_RESET   = 1;
  localparam int F_DEFAULT = 2;
  localparam int F_SUSPEND = 3;
  localparam int F_WAKE    = 4;
  localparam int F_ADDR    = 5;
  localparam int F_CFG     = 6;

  // flags that start a walk; remote wakeup is excluded (R9)
  localparam logic [FLAG_W-1:0] WALK_MASK = ~(FLAG_W'(1) << F_WAKE);

  typedef enum logic [2:0] {
    ST_ATTACHED   = 3'd0,
    ST_POWERED    = 3'd1,
    ST_DEFAULT    = 3'd2,
    ST_ADDRESSED  = 3'd3,
    ST_CONFIGURED = 3'd4
  } dev_state_e;

  typedef enum logic [3:0] {
    EV_NONE      = 4'd0,
    EV_HUB_CFG   = 4'd1,
    EV_BUS_RESET = 4'd2,
    EV_ADDR_SET  = 4'd3,
    EV_CFG_SET   = 4'd4,
    EV_CFG_CLR   = 4'd5,
    EV_PWR_LOSS  = 4'd6,
    EV_HUB_RESET = 4'd7,
    EV_BUS_IDLE  = 4'd8,
    EV_BUS_ACT   = 4'd9
  } dev_event_e;

  function automatic dev_event_e step_up_event(input dev_state_e s);
    case (s)
      ST_ATTACHED:  return EV_HUB_CFG;
      ST_POWERED:   return EV_BUS_RESET;
      ST_DEFAULT:   return EV_ADDR_SET;
      ST_ADDRESSED: return EV_CFG_SET;
      default:      return EV_NONE;
    endcase
  endfunction

  function automatic dev_event_e step_down_event(input dev_state_e s);
    case (s)
      ST_CONFIGURED: return EV_CFG_CLR;
      ST_ADDRESSED:  return EV_BUS_RESET;
      ST_DEFAULT:    return EV_PWR_LOSS;
      ST_POWERED:    return EV_HUB_RESET;
      default:       return EV_NONE;
    endcase
  endfunction

endpackage

// File: rtl/usbst_change_detect.sv
module usbst_change_detect
  import usbst_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] pending_o
);

  logic [W-1:0] snap_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  // one pending bit per flag: loaded from the difference, cleared by the walker
  for (genvar g = 0; g < W; g++) begin : g_flag
    assign pend_d[g] = accept_i ? ((word_i[g] ^ snap_q[g]) & WALK_MASK[g])
                                : (pend_q[g] & ~clr_i[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      pend_q <= '0;
    end else begin
      if (accept_i) snap_q <= word_i;
      pend_q <= pend_d;
    end
  end

  assign level_o   = snap_q;
  assign pending_o = pend_q;

endmodule

// File: rtl/usbst_prio_pick.sv
module usbst_prio_pick #(
  parameter int W = 7
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] sel_o
);

  // lowest index wins: bit order equals handling order
  always_comb begin
    sel_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = W'(1) << i;
    end
  end

endmodule

// File: rtl/usbst_walker.sv
module usbst_walker
  import usbst_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] clr_o,
  output dev_state_e   state_o,
  output logic         evt_valid_o,
  output dev_event_e   evt_code_o
);

  dev_state_e state_q, state_d, tgt;
  dev_event_e evt_q, evt_d;
  logic       evt_valid_q;
  logic       rise, act, up, susp;

  // decode the selected flag into direction and target level
  always_comb begin
    rise = |(sel_i & level_i);
    act  = 1'b0;
    up   = rise;
    susp = 1'b0;
    tgt  = ST_ATTACHED;
    if (sel_i[F_ATTACH]) begin
      act = 1'b1;
      tgt = rise ? ST_POWERED : ST_ATTACHED;
    end else if (sel_i[F_RESET]) begin
      act = rise;
      up  = 1'b0;
      tgt = ST_POWERED;
    end else if (sel_i[F_DEFAULT]) begin
      act = 1'b1;
      tgt = rise ? ST_DEFAULT : ST_POWERED;
    end else if (sel_i[F_SUSPEND]) begin
      susp = 1'b1;
    end else if (sel_i[F_ADDR]) begin
      act = 1'b1;
      tgt = rise ? ST_ADDRESSED : ST_DEFAULT;
    end else if (sel_i[F_CFG]) begin
      act = 1'b1;
      tgt = rise ? ST_CONFIGURED : ST_ADDRESSED;
    end
  end

  // one step per cycle; the flag retires when its target is reached
  always_comb begin
    state_d = state_q;
    evt_d   = EV_NONE;
    clr_o   = '0;
    if (susp) begin
      evt_d = rise ? EV_BUS_IDLE : EV_BUS_ACT;
      clr_o = sel_i;
    end else if (act && up && (state_q < tgt)) begin
      state_d = dev_state_e'(state_q + 3'd1);
      evt_d   = step_up_event(state_q);
      if (state_d == tgt) clr_o = sel_i;
    end else if (act && !up && (state_q > tgt)) begin
      state_d = dev_state_e'(state_q - 3'd1);
      evt_d   = step_down_event(state_q);
      if (state_d == tgt) clr_o = sel_i;
    end else begin
      clr_o = sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_ATTACHED;
      evt_q       <= EV_NONE;
      evt_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      evt_q       <= evt_d;
      evt_valid_q <= (evt_d != EV_NONE);
    end
  end

  assign state_o     = state_q;
  assign evt_code_o  = evt_q;
  assign evt_valid_o = evt_valid_q;

endmodule

// File: rtl/usbst_tracker.sv
module usbst_tracker
  import usbst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  input  logic [FLAG_W-1:0] stat_word,
  output logic              stat_ready,
  output logic [2:0]        dev_state,
  output logic              evt_valid,
  output logic [3:0]        evt_code
);

  logic [FLAG_W-1:0] level, pending, sel, clr;
  logic              accept;
  dev_state_e        state;
  dev_event_e        code;

  assign stat_ready = (pending == '0);
  assign accept     = stat_valid & stat_ready;

  usbst_change_detect #(.W(FLAG_W)) detect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .word_i    (stat_word),
    .clr_i     (clr),
    .level_o   (level),
    .pending_o (pending)
  );

  usbst_prio_pick #(.W(FLAG_W)) pick_i (
    .req_i (pending),
    .sel_o (sel)
  );

  usbst_walker #(.W(FLAG_W)) walk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel),
    .level_i     (level),
    .clr_o       (clr),
    .state_o     (state),
    .evt_valid_o (evt_valid),
    .evt_code_o  (code)
  );

  assign dev_state = state;
  assign evt_code  = code;

endmodule

// File: rtl/usbst_tracker_chk.sv
module usbst_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_valid,
  input logic [6:0] stat_word,
  input logic       stat_ready,
  input logic [2:0] dev_state,
  input logic       evt_valid,
  input logic [3:0] evt_code
);

  assert_state_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_state <= 3'd4);

  assert_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == $past(dev_state)) || (dev_state == $past(dev_state) + 3'd1) ||
    ($past(dev_state) == dev_state + 3'd1));

  assert_step_has_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state != $past(dev_state)) |-> evt_valid);

  assert_up_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == 4'd1 || evt_code == 4'd3 || evt_code == 4'd4))
      |-> (dev_state == $past(dev_state) + 3'd1));

  assert_down_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code >= 4'd5) && (evt_code <= 4'd7))
      |-> ($past(dev_state) == dev_state + 3'd1));

  assert_reset_code_lands_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 4'd2) |-> (dev_state == 3'd2 && !$stable(dev_state)));

  assert_suspend_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == 4'd8 || evt_code == 4'd9)) |-> $stable(dev_state));

  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code >= 4'd1 && evt_code <= 4'd9));

  assert_ready_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |=> !evt_valid);

endmodule

bind usbst_tracker usbst_tracker_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .stat_valid (stat_valid),
  .stat_word  (stat_word),
  .stat_ready (stat_ready),
  .dev_state  (dev_state),
  .evt_valid  (evt_valid),
  .evt_code   (evt_code)
);

// File: tb/usbst_tracker_tb_top.sv
module usbst_tracker_tb_top;

  logic       clk;
  logic       rst_n;
  logic       stat_valid;
  logic [6:0] stat_word;
  logic       stat_ready;
  logic [2:0] dev_state;
  logic       evt_valid;
  logic [3:0] evt_code;

  int n_checks = 0;
  int n_fails  = 0;
  int m_state  = 0;
  logic [6:0] m_prev = '0;
  int exp_q[$];
  int got_q[$];

  usbst_tracker dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_valid (stat_valid),
    .stat_word  (stat_word),
    .stat_ready (stat_ready),
    .dev_state  (dev_state),
    .evt_valid  (evt_valid),
    .evt_code   (evt_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int up_code(input int s);
    return s + 1;
  endfunction

  function automatic int down_code(input int s);
    case (s)
      4: return 5;
      3: return 2;
      2: return 6;
      default: return 7;
    endcase
  endfunction

  // reference model built from R3..R10
  task automatic model(input logic [6:0] w);
    logic [6:0] chg;
    chg = w ^ m_prev;
    exp_q.delete();
    for (int f = 0; f < 7; f++) begin
      bit r, act, up;
      int tgt;
      if (f == 4 || !chg[f]) continue;
      r = w[f];
      act = 1'b1;
      up = r;
      tgt = 0;
      case (f)
        0: tgt = r ? 1 : 0;
        1: begin act = r; up = 1'b0; tgt = 1; end
        2: tgt = r ? 2 : 1;
        5: tgt = r ? 3 : 2;
        6: tgt = r ? 4 : 3;
        default: act = 1'b0;
      endcase
      if (f == 3) exp_q.push_back(r ? 8 : 9);
      else if (act) begin
        while (up && m_state < tgt) begin exp_q.push_back(up_code(m_state)); m_state++; end
        while (!up && m_state > tgt) begin exp_q.push_back(down_code(m_state)); m_state--; end
      end
    end
    m_prev = w;
  endtask

  task automatic apply(input logic [6:0] w, input string tag, input bit poke);
    int n;
    model(w);
    @(negedge clk);
    stat_word  = w;
    stat_valid = 1'b1;
    @(negedge clk);
    stat_valid = 1'b0;
    got_q.delete();
    n = 0;
    forever begin
      if (poke && n == 0 && !stat_ready) begin
        stat_word  = ~w;
        stat_valid = 1'b1;
      end
      @(negedge clk);
      stat_valid = 1'b0;
      n++;
      if (evt_valid) got_q.push_back(int'(evt_code));
      if (stat_ready || n > 40) break;
    end
    check({tag, " event count"}, got_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      check({tag, " event code"}, got_q[k], exp_q[k]);
    check({tag, " state"}, int'(dev_state), m_state);
    @(negedge clk);
    check("R12 quiet when ready", int'(evt_valid), 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    stat_valid = 1'b0;
    stat_word  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state", int'(dev_state), 0);
    check("R1 evt_valid", int'(evt_valid), 0);
    check("R1 ready", int'(stat_ready), 1);
    // R1: zero snapshot, so an all-zero sample is no change (R3)
    apply(7'h00, "R3 same word", 1'b0);
    // R4/R10: all level flags at once walk 1,2,3,4
    apply(7'h65, "R4 R10 climb", 1'b0);
    // R5/R7: drop all, attach walks to bottom, the rest are no-ops
    apply(7'h00, "R5 R7 fall", 1'b0);
    // R6: attach then default, then bus reset pulls back to powered
    apply(7'h05, "R6 up", 1'b0);
    apply(7'h07, "R6 bus reset", 1'b0);
    apply(7'h05, "R6 reset clear", 1'b0);
    // R8: suspend on and off
    apply(7'h0D, "R8 idle", 1'b0);
    apply(7'h05, "R8 active", 1'b0);
    // R9: remote wakeup alone
    apply(7'h15, "R9 wakeup", 1'b0);
    apply(7'h05, "R9 wakeup clr", 1'b0);
    // R12: a busy-time sample is ignored
    apply(7'h6D, "R12 busy poke", 1'b1);
    apply(7'h00, "R12 after poke", 1'b1);
    for (int i = 0; i < 128; i++) apply(7'(i ^ (i >> 1)), "R6 gray sweep", 1'b0);
    for (int i = 0; i < 128; i++) apply(7'(i * 37 + 11), "R10 multi sweep", 1'b0);
    for (int i = 0; i < 128; i++) apply(7'(i * 91 + 5), "R11 poke sweep", (i % 3) == 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule